// File: doc/BRIEF.md
# Per-Cycle Test Period Generator

This block marks the boundaries of tester cycles by counting clocks of a reference oscillator. Each cycle has its own length. The length comes from a small period table of twelve entries, each a 16-bit count of reference clocks. Four entries are meant for ordinary vectors. Software picks one of them through a 2-bit time-set select. The other eight entries hold the extra time that the sequencer inserts when a vector does not simply follow its predecessor: a jump, a loop turn-around, or a cycle spent waiting for a match. The sequencer asks for one of these entries by raising an insertion request together with a 3-bit insertion index.

The table is loaded through a simple write port before a test starts, while the run input is low. Once run is high, the block emits a one-clock cycle-start pulse at the opening of every tester cycle. It also reports which table entry governs the cycle that has just opened. The selection for a cycle is captured on the same clock edge that raises its cycle-start pulse, so the period can change on every cycle.

Top module: `test_period_gen`

## Requirements
- R1: The table has twelve 16-bit entries, addressed 0 to 11 on `wr_addr`. Entries 0–3 are the user time sets and entries 4–11 are the insertion sets. A write with `wr_addr` of 12 or more changes no entry.
- R2: A write presented while `run` is high is ignored, and the entry keeps its earlier value.
- R3: After reset, `cyc_start` is 0 and `cur_idx` is 0. While `run` is low, no pulse is produced.
- R4: On the first rising clock edge that samples `run` high after idle, the block opens a cycle, so `cyc_start` is 1 in the following clock period.
- R5: `cyc_start` is exactly one clock wide. Consecutive pulses lie P clocks apart, where P is the stored value of the entry that governs the cycle opened by the earlier pulse.
- R6: With `ins_req` low, the entry for a cycle is the user set numbered by `tset_sel` (0–3).
- R7: With `ins_req` high, the entry is insertion set 4 + `ins_sel`, whatever the value of `tset_sel`.
- R8: The select inputs are sampled only on the edge that raises `cyc_start`. Changing them during a cycle leaves that cycle's length unchanged.
- R9: A stored value of 0 or 1 produces a cycle of 2 clocks.
- R10: When `run` is sampled low, `cyc_start` is 0 from the next clock period onward and no pulse follows. Raising `run` again restarts as in R4.
- R11: `cur_idx` changes together with `cyc_start` and shows the table entry that governs the cycle just opened. It holds its value while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Tester running; high enables cycle generation and locks the table |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Table entry to write |
| wr_data | input | 16 | Period value in reference clocks |
| tset_sel | input | 2 | User time-set select |
| ins_req | input | 1 | Insertion request, overrides the user select |
| ins_sel | input | 3 | Insertion set select |
| cyc_start | output | 1 | One-clock pulse opening each tester cycle |
| cur_idx | output | 4 | Table entry governing the current cycle |

## Verification
The first pulse after `run` is raised is due one clock later. Each following pulse is due exactly P clocks after the one before it, and `cur_idx` is updated in the same period as its pulse. The bench drives inputs at falling edges. It counts falling edges from one pulse to the next and compares that count with the stored value of the entry chosen for the cycle. It changes the selects right after it sees a pulse, so every gap shows both the selection made earlier and the selection that is now pending. Ignored writes and the stop behaviour are checked by measuring later gaps, and by watching a stretch of idle periods for any stray pulse.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int PERIOD_W   = 16;
  localparam int USER_SETS  = 4;
  localparam int INS_SETS   = 8;
  localparam int MIN_PERIOD = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/period_table.sv
module period_table #(
  parameter int PW    = 16,
  parameter int DEPTH = 12,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          lock,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [PW-1:0] rdata
);
  // Distributed RAM: one write port, asynchronous read, no reset.
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && !lock && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(raddr) < DEPTH) begin
      rdata = mem[raddr];
    end
  end
endmodule

// File: rtl/set_select.sv
module set_select #(
  parameter int USER_SETS = 4,
  parameter int INS_SETS  = 8,
  parameter int IW        = 4,
  parameter int USW       = 2,
  parameter int ISW       = 3
) (
  input  logic           ins_req,
  input  logic [USW-1:0] tset_sel,
  input  logic [ISW-1:0] ins_sel,
  output logic [IW-1:0]  pick_idx
);
  // Insertion entries sit directly above the user entries.
  always_comb begin
    if (ins_req) begin
      pick_idx = IW'(USER_SETS) + IW'(ins_sel);
    end else begin
      pick_idx = IW'(tset_sel);
    end
  end

  initial begin
    assert (USER_SETS + INS_SETS <= (1 << IW))
      else $error("index width too small for table");
  end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import pgen_pkg::*;
#(
  parameter int PW     = 16,
  parameter int IW     = 4,
  parameter int MIN_PER = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [IW-1:0] pick_idx,
  input  logic [PW-1:0] pick_raw,
  output logic          cyc_start,
  output logic [IW-1:0] cur_idx
);
  run_state_e    st_q;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] per_q;
  logic [PW-1:0] per_legal;
  logic          cyc_q;
  logic [IW-1:0] idx_q;
  logic          boundary;

  // Values below the legal floor are raised to it.
  assign per_legal = (pick_raw < PW'(MIN_PER)) ? PW'(MIN_PER) : pick_raw;
  assign boundary  = (st_q == ST_IDLE) || (cnt_q == per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      per_q <= PW'(MIN_PER);
      cyc_q <= 1'b0;
      idx_q <= '0;
    end else if (!run) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      cyc_q <= 1'b0;
    end else if (boundary) begin
      st_q  <= ST_RUN;
      cnt_q <= PW'(1);
      per_q <= per_legal;
      idx_q <= pick_idx;
      cyc_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      cyc_q <= 1'b0;
    end
  end

  assign cyc_start = cyc_q;
  assign cur_idx   = idx_q;

  // Gap tracker used only by the spacing assertion.
  logic [PW:0]   gap_q;
  logic [PW-1:0] gap_per_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      seen_q    <= 1'b0;
      gap_q     <= '0;
      gap_per_q <= '0;
    end else if (cyc_q) begin
      seen_q    <= 1'b1;
      gap_q     <= (PW+1)'(1);
      gap_per_q <= per_q;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cyc_q |=> !cyc_q);                                                  // R5
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    !run |=> !cyc_q);                                                   // R10
  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (per_q >= PW'(MIN_PER)));                      // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (cnt_q >= PW'(1) && cnt_q <= per_q));          // R5
  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (rst)
    (seen_q && run && cyc_q) |-> (gap_q == {1'b0, gap_per_q}));         // R5
endmodule

// File: rtl/test_period_gen.sv
module test_period_gen
  import pgen_pkg::*;
#(
  parameter int PW        = PERIOD_W,
  parameter int N_USER    = USER_SETS,
  parameter int N_INS     = INS_SETS,
  parameter int N_ENT     = N_USER + N_INS,
  parameter int IDX_W     = $clog2(N_ENT),
  parameter int USR_W     = $clog2(N_USER),
  parameter int INS_W     = $clog2(N_INS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [PW-1:0]    wr_data,
  input  logic [USR_W-1:0] tset_sel,
  input  logic             ins_req,
  input  logic [INS_W-1:0] ins_sel,
  output logic             cyc_start,
  output logic [IDX_W-1:0] cur_idx
);
  logic [IDX_W-1:0] pick_idx;
  logic [PW-1:0]    pick_raw;

  set_select #(
    .USER_SETS(N_USER), .INS_SETS(N_INS),
    .IW(IDX_W), .USW(USR_W), .ISW(INS_W)
  ) u_sel (
    .ins_req (ins_req),
    .tset_sel(tset_sel),
    .ins_sel (ins_sel),
    .pick_idx(pick_idx)
  );

  period_table #(.PW(PW), .DEPTH(N_ENT), .AW(IDX_W)) u_tab (
    .clk  (clk),
    .lock (run),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(pick_idx),
    .rdata(pick_raw)
  );

  cycle_timer #(.PW(PW), .IW(IDX_W), .MIN_PER(MIN_PERIOD)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .pick_idx (pick_idx),
    .pick_raw (pick_raw),
    .cyc_start(cyc_start),
    .cur_idx  (cur_idx)
  );

  AST_INS_WINS: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && $past(ins_req)) |-> (cur_idx >= IDX_W'(N_USER)));     // R7
  AST_USER_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !$past(ins_req)) |-> (cur_idx < IDX_W'(N_USER)));     // R6
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> (cyc_start || $stable(cur_idx)));                    // R11
endmodule

// File: tb/test_period_gen_test.sv
module test_period_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] tset_sel = '0;
  logic       ins_req = 1'b0;
  logic [2:0] ins_sel = '0;
  logic       cyc_start;
  logic [3:0] cur_idx;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  test_period_gen uut (
    .clk(clk), .rst(rst), .run(run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tset_sel(tset_sel), .ins_req(ins_req), .ins_sel(ins_sel),
    .cyc_start(cyc_start), .cur_idx(cur_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ent(input int a, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Count falling edges until a pulse is seen.
  task automatic wait_pulse(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!cyc_start && gap < 300);
  endtask

  task automatic start_run(input string req);
    int g;
    @(negedge clk);
    run = 1'b1;
    wait_pulse(g);
    chk({req, " first pulse"}, g, 1);
  endtask

  task automatic stop_run;
    @(negedge clk);
    run = 1'b0; ins_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    int seen = 0;
    chk("R3 reset cyc_start", int'(cyc_start), 0);
    chk("R3 reset cur_idx", int'(cur_idx), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (cyc_start) seen++;
    end
    chk("R3 idle pulses", seen, 0);
  endtask

  task automatic load_table;
    write_ent(0, 5); write_ent(1, 3); write_ent(2, 8); write_ent(3, 2);
    for (int k = 0; k < 8; k++) write_ent(4 + k, 10 + k);
  endtask

  task automatic t_user;
    int g;
    tset_sel = 2'd0;
    start_run("R4");
    chk("R11 idx first", int'(cur_idx), 0);
    tset_sel = 2'd1;   // R8: changed after the pulse, cycle stays at entry 0
    wait_pulse(g); chk("R8 R5 gap entry0", g, 5); chk("R6 idx1", int'(cur_idx), 1);
    tset_sel = 2'd2;
    wait_pulse(g); chk("R6 gap entry1", g, 3); chk("R11 idx2", int'(cur_idx), 2);
    tset_sel = 2'd3;
    wait_pulse(g); chk("R6 gap entry2", g, 8); chk("R11 idx3", int'(cur_idx), 3);
    tset_sel = 2'd0;
    wait_pulse(g); chk("R5 gap entry3", g, 2); chk("R11 idx0", int'(cur_idx), 0);
    wait_pulse(g); chk("R5 gap entry0 again", g, 5);
    stop_run;
  endtask

  task automatic t_insert;
    int g;
    tset_sel = 2'd0;
    start_run("R4 ins");
    tset_sel = 2'd3; ins_req = 1'b1; ins_sel = 3'd2;
    wait_pulse(g); chk("R7 gap entry0", g, 5); chk("R7 idx6", int'(cur_idx), 6);
    ins_sel = 3'd7;
    wait_pulse(g); chk("R7 gap entry6", g, 12); chk("R7 idx11", int'(cur_idx), 11);
    ins_req = 1'b0; tset_sel = 2'd1;
    wait_pulse(g); chk("R7 gap entry11", g, 17); chk("R6 back to user", int'(cur_idx), 1);
    wait_pulse(g); chk("R6 gap entry1", g, 3);
    stop_run;
  endtask

  task automatic t_range;
    int g;
    write_ent(12, 40); write_ent(15, 41);
    tset_sel = 2'd3;
    start_run("R1");
    tset_sel = 2'd0;
    wait_pulse(g); chk("R1 entry3 intact", g, 2);
    ins_req = 1'b1; ins_sel = 3'd0;
    wait_pulse(g); chk("R1 entry0 intact", g, 5);
    ins_sel = 3'd3;
    wait_pulse(g); chk("R1 entry4 intact", g, 10);
    ins_req = 1'b0;
    wait_pulse(g); chk("R1 entry7 intact", g, 13);
    stop_run;
  endtask

  task automatic t_lock;
    int g;
    tset_sel = 2'd0;
    start_run("R2");
    write_ent(0, 20);
    stop_run;
    start_run("R2 restart");
    wait_pulse(g); chk("R2 locked write ignored", g, 5);
    stop_run;
  endtask

  task automatic t_clamp;
    int g;
    write_ent(3, 0);
    tset_sel = 2'd3;
    start_run("R9");
    wait_pulse(g); chk("R9 value0 -> 2", g, 2);
    stop_run;
    write_ent(3, 1);
    start_run("R9 b");
    wait_pulse(g); chk("R9 value1 -> 2", g, 2);
    stop_run;
    write_ent(3, 2);
  endtask

  task automatic t_stop;
    int g;
    int seen = 0;
    tset_sel = 2'd2;
    start_run("R10");
    @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (cyc_start) seen++;
    end
    chk("R10 no pulse after stop", seen, 0);
    chk("R11 idx held idle", int'(cur_idx), 2);
    tset_sel = 2'd1;
    start_run("R10 restart");
    chk("R10 restart idx", int'(cur_idx), 1);
    wait_pulse(g); chk("R10 restart gap", g, 3);
    stop_run;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    load_table;
    t_user;
    t_insert;
    t_range;
    t_lock;
    t_clamp;
    t_stop;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule